// File: doc/BRIEF.md
# Legacy Shadow Region Access Router

This block steers host memory accesses in the legacy upper region of the first megabyte (0xC0000 through 0xFFFFF) to either system DRAM or the ROM/bus path. The region is cut into one 64 KB area at the top and twelve 16 KB areas below it. Each area has its own pair of attribute bits: one enables reads from DRAM and the other enables writes to DRAM. Reads and writes are steered independently, so firmware can copy ROM contents into DRAM and then lock DRAM as read-only.

The attribute bits are packed two slots per byte into seven configuration registers. These are read and written one byte at a time through a small configuration port. Routing is combinational on the host address, the direction and the current register contents. Host addresses outside the region always go to DRAM. A claim flag shows when the decoder owned the access.

Top module: `legacy_shadow_router`

## Requirements
- R1: After reset, all seven attribute registers (configuration offsets 0x59 to 0x5F) read back 0x00. A configuration read at any other offset returns 0x00, and a write there changes no register.
- R2: A configuration write to offset 0x59..0x5F stores all eight data bits. Reading the same offset afterwards returns exactly that byte.
- R3: Slot i lives in the register at offset 0x59 + i/2. Even slots use bits [3:0] and odd slots use bits [7:4]. In a slot's nibble, bit 0 is read enable and bit 1 is write enable.
- R4: Slot 1 covers 0xF0000..0xFFFFF. Slots 2..9 cover the 16 KB areas from 0xC0000 upward in ascending order. Slots 10..13 cover the 16 KB areas from 0xE0000 upward.
- R5: A read in a mapped area goes to DRAM (to_dram=1) when its read enable is set. When the read enable is clear, the read goes to the ROM/bus path (to_rom=1).
- R6: A write in a mapped area goes to DRAM when its write enable is set. Otherwise it goes to the ROM/bus path, leaving DRAM unmodified. This is independent of the read enable.
- R7: An access outside 0xC0000..0xFFFFF goes to DRAM with claim=0. Any access inside the region has claim=1.
- R8: Bits [3:2] and [7:6] of every register have no effect on routing.
- R9: Routing follows the address and direction in the same cycle. A configuration write changes routing starting in the cycle after the clock edge that accepts it.
- R10: A valid access asserts exactly one of to_dram and to_rom. When host_valid is low, to_dram, to_rom and claim are all 0.
- R11: Slot 0 (the low nibble of offset 0x59) is reserved. Its bits route no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| host_valid | input | 1 | Host access present |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host byte address |
| claim | output | 1 | Access lies in the shadow region |
| to_dram | output | 1 | Route the access to DRAM |
| to_rom | output | 1 | Route the access to the ROM/bus path |

## Verification
The routing function is driven with a fixed register image in which neighbouring slots carry all four enable combinations. This separates nibble selection, slot packing and the independent read and write paths. The image also sets the don't-care bits in two slots, so a decoder that reads them is exposed. Addresses sit on both edges of every area size and just outside the region, which catches off-by-one area boundaries and a mis-mapped 64 KB top area. Directed cases cover the reset image, the reserved slot, writes to offsets next to the register block, and the one-cycle delay between a configuration write and its effect on routing.

// File: rtl/legacy_shadow_router.sv
module legacy_shadow_router #(
  parameter int ADDR_W   = 20,
  parameter int NUM_REGS = 7,
  parameter logic [7:0] CFG_BASE = 8'h59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              claim,
  output logic              to_dram,
  output logic              to_rom
);
  localparam int IW = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] REGION_LO = ADDR_W'(20'hC0000);
  localparam logic [ADDR_W-1:0] REGION_HI = ADDR_W'(20'hFFFFF);

  logic [7:0] regs [NUM_REGS];
  logic [8*NUM_REGS-1:0] regs_flat;

  logic [7:0]    cfg_off;
  logic          cfg_hit;
  logic [IW-1:0] cfg_idx;

  assign cfg_off   = cfg_addr - CFG_BASE;
  assign cfg_hit   = (cfg_addr >= CFG_BASE) && (cfg_off < 8'(NUM_REGS));
  assign cfg_idx   = cfg_off[IW-1:0];
  assign cfg_rdata = cfg_hit ? regs[cfg_idx] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= 8'h00;
    end else if (cfg_wr_en && cfg_hit) begin
      regs[cfg_idx] <= cfg_wdata;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_flat
      assign regs_flat[8*g +: 8] = regs[g];
    end
  endgenerate

  logic       in_region;
  logic [3:0] slot;
  logic [7:0] attr_byte;
  logic [3:0] attr;
  logic       enabled;

  assign in_region = (host_addr >= REGION_LO) && (host_addr <= REGION_HI);

  always_comb begin
    slot = 4'd0;
    if (in_region) begin
      if (host_addr[17] && host_addr[16])
        slot = 4'd1;
      else if (host_addr[17])
        slot = 4'd10 + {2'b00, host_addr[15:14]};
      else
        slot = 4'd2 + {1'b0, host_addr[16:14]};
    end
  end

  assign attr_byte = regs[slot[3:1]];
  assign attr      = slot[0] ? attr_byte[7:4] : attr_byte[3:0];
  assign enabled   = (slot != 4'd0) && (host_write ? attr[1] : attr[0]);

  assign claim   = host_valid && in_region;
  assign to_dram = host_valid && (!in_region || enabled);
  assign to_rom  = host_valid && in_region && !enabled;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid |-> $countones({to_dram, to_rom}) == 1); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !host_valid |-> !(to_dram || to_rom || claim)); // R10
  AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !claim) |-> to_dram); // R7
  AST_ROM_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    to_rom |-> claim); // R5
  AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(regs_flat)); // R2
  AST_CFG_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_hit) |=> regs_flat[8*$past(cfg_idx) +: 8] == $past(cfg_wdata)); // R2
  AST_RESERVED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> slot != 4'd0); // R11
endmodule

// File: tb/legacy_shadow_router_test.sv
`timescale 1ns/1ps
module legacy_shadow_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        host_valid = 1'b0;
  logic        host_write = 1'b0;
  logic [19:0] host_addr = 20'h0;
  logic        claim, to_dram, to_rom;

  int checks = 0;
  int failures = 0;
  logic [7:0] mdl [7];

  always #2.5 clk = ~clk;

  legacy_shadow_router uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .host_valid(host_valid),
    .host_write(host_write), .host_addr(host_addr), .claim(claim),
    .to_dram(to_dram), .to_rom(to_rom)
  );

  // {write, address}
  localparam logic [20:0] VEC [20] = '{
    {1'b0, 20'h00000}, {1'b0, 20'hBFFFF}, {1'b0, 20'hC0000}, {1'b1, 20'hC0000},
    {1'b0, 20'hC4000}, {1'b1, 20'hC7FFF}, {1'b0, 20'hC8000}, {1'b1, 20'hC8000},
    {1'b0, 20'hCC000}, {1'b1, 20'hD0000}, {1'b0, 20'hD4000}, {1'b0, 20'hDC000},
    {1'b1, 20'hDFFFF}, {1'b0, 20'hE0000}, {1'b1, 20'hE4000}, {1'b0, 20'hE8000},
    {1'b1, 20'hEC000}, {1'b0, 20'hF0000}, {1'b1, 20'hFFFFF}, {1'b1, 20'h9FFFF}
  };

  function automatic int slot_of(logic [19:0] a);
    if (a < 20'hC0000) return 0;
    if (a >= 20'hF0000) return 1;
    if (a >= 20'hE0000) return 10 + int'((a - 20'hE0000) / 20'h4000);
    return 2 + int'((a - 20'hC0000) / 20'h4000);
  endfunction

  function automatic logic exp_dram(logic [19:0] a, logic w);
    int s;
    logic [3:0] n;
    s = slot_of(a);
    if (s == 0) return 1'b1;
    n = s[0] ? mdl[s/2][7:4] : mdl[s/2][3:0];
    return w ? n[1] : n[0];
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (a >= 8'h59 && a <= 8'h5F) mdl[a - 8'h59] = d;
  endtask

  task automatic cfg_check(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic host_check(logic [19:0] a, logic w, string tag);
    logic ed;
    logic ec;
    @(negedge clk);
    host_valid = 1'b1; host_write = w; host_addr = a;
    #1;
    ed = exp_dram(a, w);
    ec = (a >= 20'hC0000);
    chk(tag, {5'b0, claim, to_dram, to_rom}, {5'b0, ec, ed, ~ed});
    host_valid = 1'b0;
  endtask

  initial begin
    #20000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset image
    for (int i = 0; i < 7; i++) cfg_check(8'h59 + 8'(i), 8'h00, "R1 reset value");
    host_check(20'hF0000, 1'b0, "R5 reset read to rom");
    host_check(20'hC0000, 1'b1, "R6 reset write to rom");

    // R1 writes outside the block ignored
    cfg_write(8'h58, 8'hFF);
    cfg_write(8'h60, 8'hFF);
    cfg_check(8'h58, 8'h00, "R1 low neighbour");
    cfg_check(8'h60, 8'h00, "R1 high neighbour");
    cfg_check(8'h59, 8'h00, "R1 first reg untouched");
    cfg_check(8'h5F, 8'h00, "R1 last reg untouched");

    // R2 R3 R8 load the pattern
    cfg_write(8'h59, 8'h13);
    cfg_write(8'h5A, 8'h23);
    cfg_write(8'h5B, 8'h01);
    cfg_write(8'h5C, 8'h32);
    cfg_write(8'h5D, 8'h10);
    cfg_write(8'h5E, 8'h20);
    cfg_write(8'h5F, 8'hFC);
    cfg_check(8'h5F, 8'hFC, "R2 full byte readback");
    cfg_check(8'h5C, 8'h32, "R2 readback");

    // R4 R5 R6 R7 R8 R11 routing table
    for (int i = 0; i < 20; i++)
      host_check(VEC[i][19:0], VEC[i][20], "R4 R5 R6 R7 route vector");

    // R11 reserved slot: slot 0 bits set, address below region unaffected
    host_check(20'hBFFFF, 1'b1, "R11 reserved slot");
    // R8 don't-care bits: slot 12 nibble C acts as 0
    host_check(20'hE8000, 1'b1, "R8 ignored bits write");

    // R9 timing: slot 10 read enable flips one cycle after the write edge
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_addr = 20'hE0000;
    cfg_wr_en = 1'b1; cfg_addr = 8'h5E; cfg_wdata = 8'h21;
    #1;
    chk("R9 before edge", {7'b0, to_dram}, 8'h00);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    mdl[5] = 8'h21;
    #1;
    chk("R9 after edge", {7'b0, to_dram}, 8'h01);
    host_write = 1'b1;
    #1;
    chk("R9 combinational direction", {6'b0, to_dram, to_rom}, 8'h01);

    // R10 idle
    host_valid = 1'b0;
    #1;
    chk("R10 idle outputs", {5'b0, claim, to_dram, to_rom}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule